// File: doc/BRIEF.md
# Packet Timestamp Inserter

This block sits inline on a 64-bit streaming packet path and stamps each packet with the value of a free-running time counter. It copies the low 16 or 24 bits of the counter into a few bytes of the packet and leaves every other byte, the byte-enable mask and the end-of-packet marker as they were. The counter value is captured once per packet, on the cycle the first beat is accepted, and the same value is used for the whole packet.

A mode input picks where the value goes. It can go nowhere, so the data passes through untouched. It can replace the identification field of IPv4 frames. Or it can be written at a byte offset given on an input, anywhere from 0 to 1518. The stamp is written most significant byte first, at the lowest offset. If a packet is too short to hold the whole field, it is forwarded unchanged. Packet bytes map to the bus little-end first: byte 8·k+j of a packet sits in lane j (bits 8·j+7 down to 8·j) of beat k.

Top module: `ts_inserter`

## Requirements
- R1: While reset is high and in the cycle after it, `m_tvalid` is 0 and `s_tready` is 1.
- R2: When `mode_i` is 0 (off) or 3 (reserved), every output beat has the same data as the input beat.
- R3: When `mode_i` is 2 (fixed), `width_i` is 0 and the packet holds bytes `pos_i` and `pos_i`+1, those bytes become stamp bits 15:8 and 7:0, in that order.
- R4: When `mode_i` is 2 and `width_i` is 1, bytes `pos_i`, +1 and +2 become stamp bits 23:16, 15:8 and 7:0. The only legal positions are those with `pos_i` mod 8 at most 5 for 24 bits, or at most 6 for 16 bits. The highest legal offset is 1518.
- R5: The stamp is the value `ts_i` has in the cycle the packet's first beat is accepted. It is not affected by how long later beats take.
- R6: When `mode_i` is 1 (header), a packet is IPv4 if bytes 12 and 13 are 0x08 and 0x00. For such a packet, the stamp is written big-endian starting at byte 18, covering bytes 18–19 for 16 bits and bytes 18–20 for 24 bits.
- R7: In header mode, a packet whose bytes 12–13 are not 0x08, 0x00 passes through unchanged.
- R8: If any byte of the target field is beyond the packet's last valid byte, the packet passes through unchanged.
- R9: `m_tkeep` and `m_tlast` equal the input values of the same beat. Each beat appears on the outputs the cycle after it is accepted.
- R10: While `m_tvalid` is high and `m_tready` is low, the output beat holds steady and `s_tready` is low. No beat is lost or duplicated.
- R11: After a beat with `s_tlast` set, the next beat is treated as byte 0 of a new packet, even when packets arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Placement: 0 off, 1 IPv4 header, 2 fixed offset, 3 off |
| width_i | input | 1 | Stamp size: 0 = 16 bits, 1 = 24 bits |
| pos_i | input | POS_W | Byte offset used in fixed mode |
| ts_i | input | 24 | Low bits of the time counter |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted when high with `s_tvalid` |
| s_tdata | input | 64 | Input data, byte 0 in bits 7:0 |
| s_tkeep | input | 8 | Input byte enables |
| s_tlast | input | 1 | Input end of packet |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 64 | Output data |
| m_tkeep | output | 8 | Output byte enables |
| m_tlast | output | 1 | Output end of packet |

## Verification
Two things can happen in the same cycle: capturing the stamp on a packet's first beat and writing it into that same beat. This happens when the fixed offset is below 8, so the live counter value has to be spliced while it is also being stored. It also happens when a packet's last beat and the next packet's first beat are accepted on consecutive edges with no gap. The bench sets up both cases: a zero offset, and back-to-back packets under random downstream backpressure. It compares every output byte with a model that uses the counter value it saw at the first-beat handshake.

// File: rtl/ts_inserter_pkg.sv
package ts_inserter_pkg;

    localparam int BYTES      = 8;
    localparam int DATA_W     = BYTES * 8;
    localparam int LANE_W     = $clog2(BYTES);
    localparam int STAMP_W    = 24;

    // Ethernet type field and IPv4 identification field offsets
    localparam int ETYPE_OFS  = 12;
    localparam int IPID_OFS   = 18;
    localparam int ETYPE_BEAT = ETYPE_OFS / BYTES;
    localparam int ETYPE_LANE = ETYPE_OFS % BYTES;
    localparam int IPID_BEAT  = IPID_OFS / BYTES;
    localparam int IPID_LANE  = IPID_OFS % BYTES;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;

    typedef enum logic [1:0] {
        PLACE_OFF   = 2'd0,
        PLACE_HDR   = 2'd1,
        PLACE_FIXED = 2'd2,
        PLACE_RSVD  = 2'd3
    } place_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [BYTES-1:0]  keep;
        logic              last;
    } beat_t;

    // number of bytes the stamp occupies
    function automatic logic [1:0] field_bytes(input logic wide);
        return wide ? 2'd3 : 2'd2;
    endfunction

    // pick stamp byte by significance (0 = least significant)
    function automatic logic [7:0] stamp_byte(input logic [STAMP_W-1:0] ts,
                                              input logic [1:0] sig);
        case (sig)
            2'd0:    return ts[7:0];
            2'd1:    return ts[15:8];
            default: return ts[23:16];
        endcase
    endfunction

endpackage

// File: rtl/tsi_beat_tracker.sv
module tsi_beat_tracker
    import ts_inserter_pkg::*;
#(
    parameter int BEAT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic               last,
    input  logic [15:0]        etype_bytes,
    input  logic [1:0]         etype_keep,
    input  logic [STAMP_W-1:0] ts_i,
    output logic [BEAT_W-1:0]  beat_idx,
    output logic [STAMP_W-1:0] stamp,
    output logic               is_ipv4
);

    localparam logic [BEAT_W-1:0] BEAT_SAT = '1;

    logic [BEAT_W-1:0]  cnt_q;
    logic [STAMP_W-1:0] ts_q;
    logic               ipv4_q;
    logic               first;
    logic               etype_hit;

    assign first    = (cnt_q == '0);
    assign beat_idx = cnt_q;
    // first beat uses the live value so an offset below 8 sees it too
    assign stamp    = first ? ts_i : ts_q;
    assign is_ipv4  = ipv4_q;

    // bytes in wire order: lower lane carries the high byte of the type
    assign etype_hit = (&etype_keep) &&
                       (etype_bytes[7:0]  == ETYPE_IPV4[15:8]) &&
                       (etype_bytes[15:8] == ETYPE_IPV4[7:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (fire) begin
            if (last)
                cnt_q <= '0;
            else if (cnt_q != BEAT_SAT)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ts_q <= '0;
        else if (fire && first)
            ts_q <= ts_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ipv4_q <= 1'b0;
        end else if (fire) begin
            if (first)
                ipv4_q <= 1'b0;
            else if (cnt_q == BEAT_W'(ETYPE_BEAT))
                ipv4_q <= etype_hit;
        end
    end

    // counter returns to zero after an end-of-packet beat
    p_restart_r11: assert property (@(posedge clk) disable iff (rst)
        (fire && last) |=> (beat_idx == '0));

    // the held stamp does not move within a packet
    p_hold_stamp_r5: assert property (@(posedge clk) disable iff (rst)
        (!(fire && first)) |=> $stable(ts_q));

endmodule

// File: rtl/tsi_splice.sv
module tsi_splice
    import ts_inserter_pkg::*;
#(
    parameter int POS_W  = 11,
    parameter int BEAT_W = 8
) (
    input  beat_t              in_beat,
    input  logic [BEAT_W-1:0]  beat_idx,
    input  place_e             mode,
    input  logic               wide,
    input  logic [POS_W-1:0]   pos,
    input  logic [STAMP_W-1:0] stamp,
    input  logic               is_ipv4,
    output beat_t              out_beat
);

    logic [31:0]       tgt_beat;
    logic [LANE_W-1:0] start;
    logic [1:0]        nbytes;
    logic              place_en;
    logic [BYTES-1:0]  field_mask;
    logic              fits;
    logic              hit;

    assign nbytes = field_bytes(wide);

    always_comb begin
        tgt_beat = 32'(IPID_BEAT);
        start    = LANE_W'(IPID_LANE);
        place_en = 1'b0;
        case (mode)
            PLACE_FIXED: begin
                tgt_beat = 32'(pos >> LANE_W);
                start    = pos[LANE_W-1:0];
                place_en = 1'b1;
            end
            PLACE_HDR: begin
                place_en = is_ipv4;
            end
            default: place_en = 1'b0;
        endcase
    end

    // every byte of the field must be present in this beat
    assign fits = &(~field_mask | in_beat.keep);
    assign hit  = place_en && fits && (32'(beat_idx) == tgt_beat);

    for (genvar l = 0; l < BYTES; l++) begin : g_lane
        logic              in_fld;
        logic [LANE_W-1:0] rank;
        logic [1:0]        sig;

        assign in_fld = (LANE_W'(l) >= start) &&
                        ((LANE_W + 1)'(l) < ({1'b0, start} + (LANE_W + 1)'(nbytes)));
        assign rank   = LANE_W'(l) - start;
        assign sig    = nbytes - 2'd1 - rank[1:0];
        assign field_mask[l] = in_fld;

        assign out_beat.data[8*l +: 8] = (hit && in_fld) ? stamp_byte(stamp, sig)
                                                         : in_beat.data[8*l +: 8];
    end

    assign out_beat.keep = in_beat.keep;
    assign out_beat.last = in_beat.last;

endmodule

// File: rtl/tsi_out_stage.sv
module tsi_out_stage
    import ts_inserter_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    input  beat_t in_beat,
    output logic  out_valid,
    input  logic  out_ready,
    output beat_t out_beat
);

    logic  valid_q;
    beat_t beat_q;

    assign in_ready  = !valid_q || out_ready;
    assign out_valid = valid_q;
    assign out_beat  = beat_q;

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else if (in_ready)
            valid_q <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (rst)
            beat_q <= '0;
        else if (in_valid && in_ready)
            beat_q <= in_beat;
    end

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_beat)));

    p_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/ts_inserter.sv
module ts_inserter
    import ts_inserter_pkg::*;
#(
    parameter int POS_W      = 11,
    parameter int MAX_OFFSET = 1518
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode_i,
    input  logic               width_i,
    input  logic [POS_W-1:0]   pos_i,
    input  logic [STAMP_W-1:0] ts_i,
    input  logic               s_tvalid,
    output logic               s_tready,
    input  logic [DATA_W-1:0]  s_tdata,
    input  logic [BYTES-1:0]   s_tkeep,
    input  logic               s_tlast,
    output logic               m_tvalid,
    input  logic               m_tready,
    output logic [DATA_W-1:0]  m_tdata,
    output logic [BYTES-1:0]   m_tkeep,
    output logic               m_tlast
);

    localparam int BEAT_W = $clog2(MAX_OFFSET / BYTES + 2);

    beat_t              in_beat;
    beat_t              spliced;
    beat_t              out_beat;
    logic               fire;
    logic [BEAT_W-1:0]  beat_idx;
    logic [STAMP_W-1:0] stamp;
    logic               is_ipv4;
    place_e             mode;

    assign in_beat = '{data: s_tdata, keep: s_tkeep, last: s_tlast};
    assign fire    = s_tvalid && s_tready;
    assign mode    = place_e'(mode_i);

    tsi_beat_tracker #(.BEAT_W(BEAT_W)) u_track (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .last        (s_tlast),
        .etype_bytes (s_tdata[8*ETYPE_LANE +: 16]),
        .etype_keep  (s_tkeep[ETYPE_LANE +: 2]),
        .ts_i        (ts_i),
        .beat_idx    (beat_idx),
        .stamp       (stamp),
        .is_ipv4     (is_ipv4)
    );

    tsi_splice #(.POS_W(POS_W), .BEAT_W(BEAT_W)) u_splice (
        .in_beat  (in_beat),
        .beat_idx (beat_idx),
        .mode     (mode),
        .wide     (width_i),
        .pos      (pos_i),
        .stamp    (stamp),
        .is_ipv4  (is_ipv4),
        .out_beat (spliced)
    );

    tsi_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s_tvalid),
        .in_ready  (s_tready),
        .in_beat   (spliced),
        .out_valid (m_tvalid),
        .out_ready (m_tready),
        .out_beat  (out_beat)
    );

    assign m_tdata = out_beat.data;
    assign m_tkeep = out_beat.keep;
    assign m_tlast = out_beat.last;

    p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
        (fire && (mode_i == 2'd0 || mode_i == 2'd3)) |=> (m_tdata == $past(s_tdata)));

    p_side_r9: assert property (@(posedge clk) disable iff (rst)
        fire |=> (m_tkeep == $past(s_tkeep) && m_tlast == $past(s_tlast)));

    p_non_ip_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && mode_i == 2'd1 && !is_ipv4) |=> (m_tdata == $past(s_tdata)));

endmodule

// File: tb/ts_inserter_tb.sv
module ts_inserter_tb;

    typedef struct packed {
        logic [1:0]  mode;
        logic        wide;
        logic [10:0] pos;
        logic [10:0] len;
        logic        ip;
        logic        bp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 11'd5,    11'd64,   1'b1, 1'b0},
        '{2'd2, 1'b0, 11'd0,    11'd64,   1'b0, 1'b1},
        '{2'd2, 1'b0, 11'd14,   11'd100,  1'b0, 1'b1},
        '{2'd2, 1'b1, 11'd21,   11'd80,   1'b0, 1'b0},
        '{2'd2, 1'b1, 11'd1512, 11'd1518, 1'b0, 1'b1},
        '{2'd2, 1'b0, 11'd1518, 11'd1520, 1'b0, 1'b0},
        '{2'd1, 1'b0, 11'd0,    11'd64,   1'b1, 1'b0},
        '{2'd1, 1'b1, 11'd0,    11'd60,   1'b1, 1'b1},
        '{2'd1, 1'b0, 11'd0,    11'd64,   1'b0, 1'b1},
        '{2'd2, 1'b1, 11'd37,   11'd30,   1'b0, 1'b0},
        '{2'd2, 1'b0, 11'd38,   11'd39,   1'b0, 1'b1},
        '{2'd1, 1'b1, 11'd0,    11'd20,   1'b1, 1'b0},
        '{2'd3, 1'b1, 11'd2,    11'd48,   1'b1, 1'b1}
    };
    string tags [NV] = '{"R2", "R3", "R3", "R4", "R5", "R3", "R6",
                         "R6", "R7", "R8", "R8", "R8", "R2"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = '0;
    logic        width_i = 1'b0;
    logic [10:0] pos_i = '0;
    logic [23:0] ts_i = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [63:0] s_tdata = '0;
    logic [7:0]  s_tkeep = '0;
    logic        s_tlast = 1'b0;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic [63:0] m_tdata;
    logic [7:0]  m_tkeep;
    logic        m_tlast;

    ts_inserter u_dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .width_i(width_i), .pos_i(pos_i),
        .ts_i(ts_i), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .s_tkeep(s_tkeep), .s_tlast(s_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast)
    );

    always #5 clk = ~clk;

    always @(posedge clk) ts_i <= ts_i + 24'h13_5B97;

    int          n_chk = 0;
    int          n_fail = 0;
    logic        bp_en = 1'b0;
    logic        force_low = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0]  pkt [2048];
    logic [7:0]  ebytes [2048];
    logic [63:0] exp_d [1024];
    logic [7:0]  exp_k [1024];
    logic        exp_l [1024];
    int          exp_n = 0;
    logic [63:0] out_d [1024];
    logic [7:0]  out_k [1024];
    logic        out_l [1024];
    int          out_n = 0;

    // downstream ready pattern
    initial forever begin
        @(posedge clk); #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (force_low)  m_tready = 1'b0;
        else if (bp_en) m_tready = lfsr[0] | lfsr[5];
        else            m_tready = 1'b1;
    end

    // output collector: beats that will transfer on the coming edge
    initial forever begin
        @(posedge clk); #8;
        if (m_tvalid === 1'b1 && m_tready === 1'b1 && out_n < 1024) begin
            out_d[out_n] = m_tdata;
            out_k[out_n] = m_tkeep;
            out_l[out_n] = m_tlast;
            out_n++;
        end
    end

    task automatic send_pkt(input logic [1:0] md, input logic wd, input int pos,
                            input int len, input logic ip, input int seed);
        int          nb;
        logic        acc;
        logic [23:0] ts_cap;
        int          start;
        int          n;
        logic        apply;
        mode_i  = md;
        width_i = wd;
        pos_i   = 11'(pos);
        for (int i = 0; i < len; i++) pkt[i] = 8'(i * 13 + seed * 29 + 5);
        if (len > 13) begin
            pkt[12] = ip ? 8'h08 : 8'h86;
            pkt[13] = ip ? 8'h00 : 8'hDD;
        end
        nb = (len + 7) / 8;
        ts_cap = '0;
        for (int b = 0; b < nb; b++) begin
            s_tvalid = 1'b1;
            for (int j = 0; j < 8; j++) begin
                s_tdata[8*j +: 8] = (b*8 + j < len) ? pkt[b*8 + j] : 8'h00;
                s_tkeep[j]        = (b*8 + j < len);
            end
            s_tlast = (b == nb - 1);
            do begin
                #6;
                acc = s_tready;
                if (acc && b == 0) ts_cap = ts_i;
                @(posedge clk); #2;
            end while (!acc);
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
        // expected bytes from the requirements
        for (int i = 0; i < len; i++) ebytes[i] = pkt[i];
        n = wd ? 3 : 2;
        apply = 1'b0;
        start = 0;
        if (md == 2'd2) begin apply = 1'b1; start = pos; end
        else if (md == 2'd1) begin apply = ip && (len >= 14); start = 18; end
        if (apply && start + n <= len)
            for (int k = 0; k < n; k++) ebytes[start + k] = 8'(ts_cap >> (8 * (n - 1 - k)));
        for (int b = 0; b < nb; b++) begin
            for (int j = 0; j < 8; j++) begin
                exp_d[exp_n][8*j +: 8] = (b*8 + j < len) ? ebytes[b*8 + j] : 8'h00;
                exp_k[exp_n][j]        = (b*8 + j < len);
            end
            exp_l[exp_n] = (b == nb - 1);
            exp_n++;
        end
    endtask

    task automatic check_group(input string tag);
        int  w;
        int  bad;
        w = 0;
        while (out_n < exp_n && w < 4000) begin @(posedge clk); w++; end
        @(posedge clk); #2;
        n_chk++;
        bad = -1;
        if (out_n != exp_n) begin
            n_fail++;
            $display("FAIL %s beat count actual %0d expected %0d", tag, out_n, exp_n);
        end else begin
            for (int i = 0; i < exp_n; i++)
                if (bad < 0 && (out_d[i] !== exp_d[i] || out_k[i] !== exp_k[i] ||
                                out_l[i] !== exp_l[i])) bad = i;
            if (bad >= 0) begin
                n_fail++;
                $display("FAIL %s beat %0d actual %h/%h/%b expected %h/%h/%b (R9 fields)",
                         tag, bad, out_d[bad], out_k[bad], out_l[bad],
                         exp_d[bad], exp_k[bad], exp_l[bad]);
            end
        end
        out_n = 0;
        exp_n = 0;
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(posedge clk);
        #8;
        // R1: reset state
        check_bit("R1 m_tvalid in reset", m_tvalid, 1'b0);
        @(posedge clk); #2;
        rst = 1'b0;
        #6;
        check_bit("R1 s_tready after reset", s_tready, 1'b1);
        check_bit("R1 m_tvalid after reset", m_tvalid, 1'b0);
        @(posedge clk); #2;

        for (int v = 0; v < NV; v++) begin
            bp_en = VEC[v].bp;
            send_pkt(VEC[v].mode, VEC[v].wide, int'(VEC[v].pos), int'(VEC[v].len),
                     VEC[v].ip, v + 1);
            check_group(tags[v]);
        end

        // R11: back-to-back packets with backpressure
        bp_en = 1'b1;
        send_pkt(2'd2, 1'b0, 10, 24, 1'b0, 40);
        send_pkt(2'd2, 1'b1, 3, 17, 1'b0, 41);
        send_pkt(2'd1, 1'b1, 0, 40, 1'b1, 42);
        check_group("R11");
        bp_en = 1'b0;

        // R10: stall holds the output beat
        force_low = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        mode_i = 2'd0;
        held = 64'h0123_4567_89AB_CDEF;
        s_tvalid = 1'b1; s_tdata = held; s_tkeep = 8'hFF; s_tlast = 1'b1;
        @(posedge clk); #2;
        s_tvalid = 1'b0; s_tlast = 1'b0;
        for (int c = 0; c < 3; c++) begin
            #6;
            check_bit("R10 s_tready low while stalled", s_tready, 1'b0);
            check_bit("R10 data held while stalled", m_tvalid && (m_tdata === held), 1'b1);
            @(posedge clk); #2;
        end
        force_low = 1'b0;
        exp_d[0] = held; exp_k[0] = 8'hFF; exp_l[0] = 1'b1; exp_n = 1;
        check_group("R10");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule